// File: doc/BRIEF.md
# GPIB Listener Acceptor Handshake

This block takes the listening side of the three-wire byte handshake on a GPIB-style parallel instrument bus. It watches the data-valid line and drives the two acceptor lines, not-ready-for-data and not-data-accepted. Each byte is captured from the active-low data lines into a data-in register. The ready line stays low after every byte until the host CPU or a DMA engine reads that register. NDAC is released a fixed number of clocks after the byte is captured.

Every byte is checked for end of message as it arrives. A byte ends the message when any of these holds:
- it matches a programmable end-of-string byte, compared on all 8 bits or on the low 7 only;
- it is the newline code;
- it arrives with the end-or-identify line asserted.

While the attention line is asserted, every device must accept command bytes. The block therefore takes part in the handshake even when it is not addressed as a listener. When attention rises, it pulls NDAC low at once. Command bytes do not wait for a host read.

Each new byte raises either a one-cycle interrupt pulse or a level DMA request. All bus inputs are taken as already synchronised to `clk_i`. A bus line is asserted when it is low.

Top module: `gpib_acceptor`

## Requirements
- R1: After reset, `din_valid_o`, `din_irq_o` and `dma_req_o` are 0. With `listen_i`=1, `nrfd_no`=1 (ready) and `ndac_no`=0.
- R2: When the block is inactive (`listen_i`=0 and `atn_ni`=1), both `nrfd_no` and `ndac_no` are 1, and an asserted `dav_ni` captures nothing (`din_valid_o` stays 0).
- R3: When active and ready, a clock edge that samples `dav_ni`=0 does three things. It loads `din_o` with the bitwise inverse of `dio_ni`. It sets `din_valid_o`. It drives `nrfd_no` low from that edge on.
- R4: `ndac_no` goes high exactly NDAC_DLY clock edges after the capture edge (default 3).
- R5: The edge after `dav_ni` is sampled high again drives `ndac_no` low.
- R6: For a data byte (taken with `atn_ni`=1), `nrfd_no` stays low after DAV is released until an edge where `rd_i`=1 and `holdoff_i`=0. The first such edge releases it. `rd_i` clears `din_valid_o`. While `holdoff_i`=1, NRFD stays low even after the read.
- R7: An edge that samples `atn_ni` going low drives `ndac_no` low from that edge on, even right after NDAC was released. Bytes taken with ATN asserted set `cmd_o`=1. They release NRFD one edge after DAV is released, with no read needed.
- R8: With `eos_en_i`=1, a data byte equal to `eos_byte_i` sets `end_o`. With `eos_7bit_i`=1, only bits 6..0 are compared.
- R9: With `nl_en_i`=1, a data byte of 8'h0A sets `end_o`.
- R10: A data byte taken with `eoi_ni`=0 sets `end_o`. A byte taken with ATN asserted never sets `end_o`.
- R11: On capture, `din_irq_o` pulses for exactly one cycle if `din_ie_i`=1 and `dma_in_i`=0. `dma_req_o` is high while an unread data byte is held and `dma_in_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| listen_i | input | 1 | Listener addressed |
| dav_ni | input | 1 | Bus data valid, active low |
| atn_ni | input | 1 | Bus attention, active low |
| eoi_ni | input | 1 | Bus end-or-identify, active low |
| dio_ni | input | 8 | Bus data lines, active low |
| nrfd_no | output | 1 | Not ready for data drive (0 pulls low) |
| ndac_no | output | 1 | Not data accepted drive (0 pulls low) |
| rd_i | input | 1 | Data-in register read strobe (CPU or DMA) |
| holdoff_i | input | 1 | Hold NRFD low regardless of read |
| eos_byte_i | input | 8 | End-of-string byte |
| eos_en_i | input | 1 | Enable end-of-string compare |
| eos_7bit_i | input | 1 | Compare only bits 6..0 |
| nl_en_i | input | 1 | Treat newline (8'h0A) as end |
| din_ie_i | input | 1 | Data-in interrupt enable |
| dma_in_i | input | 1 | DMA-in enable |
| din_o | output | 8 | Data-in register |
| din_valid_o | output | 1 | Unread byte held |
| end_o | output | 1 | Held byte ends the message |
| cmd_o | output | 1 | Held byte was taken with ATN asserted |
| din_irq_o | output | 1 | One-cycle data-in interrupt pulse |
| dma_req_o | output | 1 | DMA request for the held byte |

## Verification
Some properties are checked on every cycle:
- both lines float while the block is inactive;
- NRFD drops after DAV is sampled low;
- NDAC drops after DAV is released and after ATN is asserted;
- NRFD stays low while an unread data byte is held;
- the interrupt never lasts more than one cycle;
- a DMA request is never raised without a held byte.

The exact NDAC release delay, the captured value and the end-of-message flag under each compare mode can only be shown by the bench's scenarios. The same applies to the holdoff input and to command bytes releasing without a read.

// File: rtl/gpib_ah_pkg.sv
package gpib_ah_pkg;
  typedef enum logic [1:0] {
    AH_READY  = 2'd0,
    AH_ACCEPT = 2'd1,
    AH_DONE   = 2'd2,
    AH_HOLD   = 2'd3
  } ah_state_e;
endpackage

// File: rtl/gpib_ah_ctrl.sv
module gpib_ah_ctrl
  import gpib_ah_pkg::*;
#(
  parameter int NDAC_DLY = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      active_i,
  input  logic      dav_i,
  input  logic      atn_i,
  input  logic      release_ok_i,
  output logic      latch_o,
  output ah_state_e st_o
);
  localparam int CW = $clog2(NDAC_DLY + 1);

  ah_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic atn_q;
  logic atn_rise;

  assign atn_rise = atn_i & ~atn_q;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    latch_o = 1'b0;
    if (!active_i) begin
      st_d = AH_READY;
    end else begin
      unique case (st_q)
        AH_READY: if (dav_i) begin
          latch_o = 1'b1;
          cnt_d   = '0;
          st_d    = AH_ACCEPT;
        end
        AH_ACCEPT: begin
          if (!dav_i) st_d = AH_HOLD;
          else if (cnt_q == CW'(NDAC_DLY - 1)) st_d = AH_DONE;
          else cnt_d = cnt_q + 1'b1;
        end
        // DAV release or a fresh ATN both pull NDAC back low
        AH_DONE: if (!dav_i || atn_rise) st_d = AH_HOLD;
        AH_HOLD: if (!dav_i && release_ok_i) st_d = AH_READY;
        default: st_d = AH_READY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= AH_READY;
      cnt_q <= '0;
      atn_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      atn_q <= atn_i;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/gpib_ah_end_det.sv
module gpib_ah_end_det #(
  parameter int W = 8
) (
  input  logic [W-1:0] byte_i,
  input  logic [W-1:0] eos_byte_i,
  input  logic         eos_en_i,
  input  logic         eos_7bit_i,
  input  logic         nl_en_i,
  input  logic         eoi_i,
  input  logic         atn_i,
  output logic         end_o
);
  localparam logic [W-1:0] NL_CODE = W'(10);
  localparam logic [W-1:0] MASK7   = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] mask;
  logic eos_hit, nl_hit;

  assign mask    = eos_7bit_i ? MASK7 : '1;
  assign eos_hit = eos_en_i && ((byte_i & mask) == (eos_byte_i & mask));
  assign nl_hit  = nl_en_i && (byte_i == NL_CODE);
  // EOI with ATN is a poll, never end of message
  assign end_o   = ~atn_i & (eos_hit | nl_hit | eoi_i);
endmodule

// File: rtl/gpib_ah_din.sv
module gpib_ah_din #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic [W-1:0] byte_i,
  input  logic         atn_i,
  input  logic         end_i,
  input  logic         rd_i,
  input  logic         din_ie_i,
  input  logic         dma_in_i,
  output logic [W-1:0] din_o,
  output logic         valid_o,
  output logic         end_o,
  output logic         cmd_o,
  output logic         irq_o,
  output logic         dma_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_o   <= '0;
      valid_o <= 1'b0;
      end_o   <= 1'b0;
      cmd_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (latch_i) begin
        din_o   <= byte_i;
        valid_o <= 1'b1;
        end_o   <= end_i;
        cmd_o   <= atn_i;
        irq_o   <= din_ie_i & ~dma_in_i;
      end else if (rd_i) begin
        valid_o <= 1'b0;
      end
    end
  end

  assign dma_req_o = valid_o & dma_in_i & ~cmd_o;
endmodule

// File: rtl/gpib_acceptor.sv
module gpib_acceptor
  import gpib_ah_pkg::*;
#(
  parameter int W        = 8,
  parameter int NDAC_DLY = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         listen_i,
  input  logic         dav_ni,
  input  logic         atn_ni,
  input  logic         eoi_ni,
  input  logic [W-1:0] dio_ni,
  output logic         nrfd_no,
  output logic         ndac_no,
  input  logic         rd_i,
  input  logic         holdoff_i,
  input  logic [W-1:0] eos_byte_i,
  input  logic         eos_en_i,
  input  logic         eos_7bit_i,
  input  logic         nl_en_i,
  input  logic         din_ie_i,
  input  logic         dma_in_i,
  output logic [W-1:0] din_o,
  output logic         din_valid_o,
  output logic         end_o,
  output logic         cmd_o,
  output logic         din_irq_o,
  output logic         dma_req_o
);
  logic         atn, active, latch, end_now, release_ok;
  logic [W-1:0] bus_byte;
  ah_state_e    st;

  assign atn      = ~atn_ni;
  assign active   = listen_i | atn;
  assign bus_byte = ~dio_ni;
  // command bytes need no read before release
  assign release_ok = (~din_valid_o | rd_i | cmd_o) & ~holdoff_i;

  gpib_ah_ctrl #(.NDAC_DLY(NDAC_DLY)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active),
    .dav_i        (~dav_ni),
    .atn_i        (atn),
    .release_ok_i (release_ok),
    .latch_o      (latch),
    .st_o         (st)
  );

  gpib_ah_end_det #(.W(W)) u_end (
    .byte_i     (bus_byte),
    .eos_byte_i (eos_byte_i),
    .eos_en_i   (eos_en_i),
    .eos_7bit_i (eos_7bit_i),
    .nl_en_i    (nl_en_i),
    .eoi_i      (~eoi_ni),
    .atn_i      (atn),
    .end_o      (end_now)
  );

  gpib_ah_din #(.W(W)) u_din (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_i   (latch),
    .byte_i    (bus_byte),
    .atn_i     (atn),
    .end_i     (end_now),
    .rd_i      (rd_i),
    .din_ie_i  (din_ie_i),
    .dma_in_i  (dma_in_i),
    .din_o     (din_o),
    .valid_o   (din_valid_o),
    .end_o     (end_o),
    .cmd_o     (cmd_o),
    .irq_o     (din_irq_o),
    .dma_req_o (dma_req_o)
  );

  assign nrfd_no = ~active | (st == AH_READY);
  assign ndac_no = ~active | (st == AH_DONE);
endmodule

// File: rtl/gpib_acceptor_chk.sv
module gpib_acceptor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic listen_i,
  input logic dav_ni,
  input logic atn_ni,
  input logic rd_i,
  input logic nrfd_no,
  input logic ndac_no,
  input logic din_valid_o,
  input logic cmd_o,
  input logic din_irq_o,
  input logic dma_req_o
);
  logic idle_bus;
  assign idle_bus = ~listen_i & atn_ni;

  AST_FLOAT_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_bus |-> (nrfd_no && ndac_no)); // R2
  AST_NRFD_ON_DAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_bus && nrfd_no && !dav_ni) |=> (!nrfd_no || idle_bus)); // R3
  AST_NDAC_ON_DAV_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_bus && $rose(dav_ni)) |=> (!ndac_no || idle_bus)); // R5
  AST_NRFD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_bus && !nrfd_no && din_valid_o && !cmd_o && !rd_i) |=> (!nrfd_no || idle_bus)); // R6
  AST_NDAC_ON_ATN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(atn_ni) |=> (!ndac_no || idle_bus)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    din_irq_o |=> !din_irq_o); // R11
  AST_DMA_NEEDS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> din_valid_o); // R11
endmodule

bind gpib_acceptor gpib_acceptor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .listen_i    (listen_i),
  .dav_ni      (dav_ni),
  .atn_ni      (atn_ni),
  .rd_i        (rd_i),
  .nrfd_no     (nrfd_no),
  .ndac_no     (ndac_no),
  .din_valid_o (din_valid_o),
  .cmd_o       (cmd_o),
  .din_irq_o   (din_irq_o),
  .dma_req_o   (dma_req_o)
);

// File: tb/gpib_acceptor_tb.sv
module gpib_acceptor_tb;
  localparam int NDAC_DLY = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic listen_i = 1'b1, dav_ni = 1'b1, atn_ni = 1'b1, eoi_ni = 1'b1;
  logic [7:0] dio_ni = 8'hFF;
  logic rd_i = 1'b0, holdoff_i = 1'b0;
  logic [7:0] eos_byte_i = 8'h00;
  logic eos_en_i = 1'b0, eos_7bit_i = 1'b0, nl_en_i = 1'b0;
  logic din_ie_i = 1'b1, dma_in_i = 1'b0;
  logic nrfd_no, ndac_no, din_valid_o, end_o, cmd_o, din_irq_o, dma_req_o;
  logic [7:0] din_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpib_acceptor #(.W(8), .NDAC_DLY(NDAC_DLY)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .listen_i(listen_i), .dav_ni(dav_ni),
    .atn_ni(atn_ni), .eoi_ni(eoi_ni), .dio_ni(dio_ni), .nrfd_no(nrfd_no),
    .ndac_no(ndac_no), .rd_i(rd_i), .holdoff_i(holdoff_i),
    .eos_byte_i(eos_byte_i), .eos_en_i(eos_en_i), .eos_7bit_i(eos_7bit_i),
    .nl_en_i(nl_en_i), .din_ie_i(din_ie_i), .dma_in_i(dma_in_i),
    .din_o(din_o), .din_valid_o(din_valid_o), .end_o(end_o), .cmd_o(cmd_o),
    .din_irq_o(din_irq_o), .dma_req_o(dma_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_end(input logic [7:0] d, input logic atn, input logic eoi);
    logic [7:0] m;
    m = eos_7bit_i ? 8'h7F : 8'hFF;
    if (atn) return 1'b0;
    return eoi || (eos_en_i && ((d & m) == (eos_byte_i & m))) || (nl_en_i && d == 8'h0A);
  endfunction

  // Drive DAV low, check capture and NDAC delay; leaves DAV low with NDAC high
  task automatic put_byte(input logic [7:0] d, input logic atn, input logic eoi);
    int n;
    logic e;
    e = exp_end(d, atn, eoi);
    @(negedge clk);
    dio_ni = ~d; atn_ni = ~atn; eoi_ni = ~eoi; dav_ni = 1'b0;
    @(negedge clk);
    chk("R3 nrfd low", nrfd_no, 0);
    chk("R3 din", din_o, d);
    chk("R3 valid", din_valid_o, 1);
    chk("R8/R9/R10 end", end_o, e);
    chk("R7 cmd flag", cmd_o, atn);
    chk("R11 irq", din_irq_o, din_ie_i & ~dma_in_i);
    chk("R11 dma", dma_req_o, dma_in_i & ~atn);
    n = 1;
    while (ndac_no == 1'b0 && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk("R4 ndac delay", n, NDAC_DLY + 1);
    chk("R11 irq one cycle", din_irq_o, 0);
  endtask

  task automatic finish_byte(input logic atn);
    dav_ni = 1'b1;
    @(negedge clk);
    chk("R5 ndac low", ndac_no, 0);
    chk("R6 nrfd held", nrfd_no, 0);
    if (atn) begin
      @(negedge clk);
      chk("R7 cmd release", nrfd_no, 1);
      atn_ni = 1'b1;
    end else begin
      repeat (2) @(negedge clk);
      chk("R6 nrfd held unread", nrfd_no, 0);
      rd_i = 1'b1;
      @(negedge clk);
      rd_i = 1'b0;
      chk("R6 released on read", nrfd_no, 1);
      chk("R6 valid cleared", din_valid_o, 0);
    end
    eoi_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid", din_valid_o, 0);
    chk("R1 irq", din_irq_o, 0);
    chk("R1 dma", dma_req_o, 0);
    chk("R1 nrfd", nrfd_no, 1);
    chk("R1 ndac", ndac_no, 0);

    // R2: inactive, DAV ignored
    listen_i = 1'b0; dio_ni = 8'h00; dav_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 nrfd float", nrfd_no, 1);
    chk("R2 ndac float", ndac_no, 1);
    chk("R2 no capture", din_valid_o, 0);
    dav_ni = 1'b1; listen_i = 1'b1;
    @(negedge clk);

    // R8 8-bit and 7-bit EOS
    eos_en_i = 1'b1; eos_byte_i = 8'hC1;
    put_byte(8'hC1, 0, 0); finish_byte(0);
    put_byte(8'h41, 0, 0); finish_byte(0);
    eos_7bit_i = 1'b1;
    put_byte(8'h41, 0, 0); finish_byte(0);
    eos_7bit_i = 1'b0; eos_en_i = 1'b0;
    // R9 newline
    nl_en_i = 1'b1;
    put_byte(8'h0A, 0, 0); finish_byte(0);
    nl_en_i = 1'b0;
    put_byte(8'h0A, 0, 0); finish_byte(0);
    // R10 EOI, and EOI under ATN
    put_byte(8'h33, 0, 1); finish_byte(0);
    put_byte(8'h33, 1, 1); finish_byte(1);

    // R7 command byte accepted while not addressed
    listen_i = 1'b0;
    put_byte(8'h3F, 1, 0); finish_byte(1);
    @(negedge clk);
    chk("R2 float after cmd", nrfd_no, 1);
    listen_i = 1'b1;

    // R7 ATN asserted while NDAC released
    put_byte(8'h55, 0, 0);
    atn_ni = 1'b0;
    @(negedge clk);
    chk("R7 ndac forced low", ndac_no, 0);
    dav_ni = 1'b1; atn_ni = 1'b1;
    @(negedge clk);
    chk("R6 nrfd held after atn off", nrfd_no, 0);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    chk("R6 release", nrfd_no, 1);

    // R6 holdoff
    put_byte(8'hA5, 0, 0);
    holdoff_i = 1'b1;
    dav_ni = 1'b1;
    @(negedge clk);
    rd_i = 1'b1; @(negedge clk); rd_i = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 holdoff keeps nrfd", nrfd_no, 0);
    chk("R6 read clears valid", din_valid_o, 0);
    holdoff_i = 1'b0;
    @(negedge clk);
    chk("R6 holdoff release", nrfd_no, 1);

    // R11 DMA mode
    dma_in_i = 1'b1;
    put_byte(8'h12, 0, 0);
    chk("R11 dma held", dma_req_o, 1);
    finish_byte(0);
    chk("R11 dma cleared", dma_req_o, 0);
    dma_in_i = 1'b0;

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] d;
      logic a, e;
      d = 8'($urandom);
      a = ($urandom % 4) == 0;
      e = ($urandom % 4) == 0;
      eos_en_i = 1'($urandom);
      eos_7bit_i = 1'($urandom);
      nl_en_i = 1'($urandom);
      din_ie_i = 1'($urandom);
      dma_in_i = 1'($urandom);
      eos_byte_i = ($urandom % 2) ? (d ^ (8'($urandom % 2) << 7)) : 8'($urandom);
      if (($urandom % 6) == 0) d = 8'h0A;
      put_byte(d, a, e);
      finish_byte(a);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule